// File: doc/BRIEF.md
# Streaming Systolic Reduction Chain

This block reduces a stream of fixed-width elements with a linear chain of identical cells. One element enters per clock. Each cell holds one result entry and one element in transit. On every clock each cell compares the element arriving from its upstream neighbour with the entry it holds. The element is then captured, dropped, merged into the entry, or passed on one cell further. A mode input selects the reduction rule. Duplicate removal compares whole elements. Monomial summation treats each element as an exponent vector and a coefficient, and it adds the coefficients of equal exponent vectors modulo a prime.

Elements that travel past the last cell without being absorbed leave the block on an overflow output, so that the surrounding logic can run them through the chain again. After the final element and a short settling gap, the flush input turns the chain into a shift register. The held entries then move toward the output one cell per clock. An entry is marked valid only when it carries a result. The flush also empties the chain, so that it is ready for the next sequence.

Element layout: bits [DATA_W-1:COEF_W] are the exponent vector and bits [COEF_W-1:0] are the coefficient. With the default parameters DATA_W is 9 and COEF_W is 3. `mode` = 0 selects duplicate removal and `mode` = 1 selects monomial summation.

Top module: `sysred_array`

## Requirements
- R1: After reset every cell is empty. A flush then yields no `out_valid`, and `ovf_valid` stays low.
- R2: In mode 0, an element equal in all bits to an entry already held is discarded. Only its first occurrence survives.
- R3: An empty cell captures the first valid element that reaches it. The k-th distinct result is therefore held in cell k-1, counted from the input side.
- R4: In mode 1, a monomial whose exponent vector equals a held entry's exponent vector is absorbed. Its coefficient is added to the entry's coefficient modulo PRIME.
- R5: In mode 1, an entry whose coefficient sums to 0 keeps its cell. It is not reported at flush, and a later monomial with the same exponent vector merges into it.
- R6: A valid element that no cell absorbs appears on `ovf_valid`/`ovf_data`. This happens after the DEPTH-th rising edge, counting the edge that took it in as the first.
- R7: While `flush` is high, each clock moves every entry one cell toward the output. `out_valid` shows the last cell's entry combinationally, and only when that entry is non-empty and, in mode 1, has a non-zero coefficient. Entries leave last cell first. DEPTH flush clocks empty the chain.
- R8: While `flush` is high, `in_valid` and `in_data` have no effect. Nothing is captured, and nothing reaches the overflow output.
- R9: The all-zero data value is an ordinary element. It can be captured, compared and reported.
- R10: A clock with `in_valid` low leaves every held entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = duplicate removal, 1 = monomial summation |
| flush | input | 1 | High = shift stored entries out instead of comparing |
| in_valid | input | 1 | Input element present |
| in_data | input | DATA_W | Input element {exponent vector, coefficient} |
| out_valid | output | 1 | Result entry present on out_data (only during flush) |
| out_data | output | DATA_W | Entry held in the last cell |
| ovf_valid | output | 1 | Element left the chain unabsorbed |
| ovf_data | output | DATA_W | The unabsorbed element |

## Verification
The cell assertions take three things for granted. `mode` stays constant from the first element of a sequence until the flush has emptied the chain. Every coefficient applied in mode 1 is below PRIME. At least DEPTH-1 idle clocks separate the last element from the start of a flush, so that no element is still in transit when shifting begins. Each bench scenario starts from an empty chain, sets the mode before its first element, and inserts four idle clocks before every flush. All coefficients are chosen from 1 to 6 for the prime 7.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;

    typedef enum logic {
        RED_DISTINCT = 1'b0,
        RED_POLYADD  = 1'b1
    } red_mode_e;

endpackage

// File: rtl/sra_mod_add.sv
`timescale 1ns/1ps
module sra_mod_add #(
    parameter int COEF_W = 3,
    parameter int PRIME  = 7
) (
    input  logic [COEF_W-1:0] a,
    input  logic [COEF_W-1:0] b,
    output logic [COEF_W-1:0] sum
);

    localparam int SUM_W = COEF_W + 1;
    localparam logic [SUM_W-1:0] MODULUS = SUM_W'(PRIME);

    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] reduced;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b};
        reduced = (raw >= MODULUS) ? (raw - MODULUS) : raw;
        sum     = reduced[COEF_W-1:0];
    end

endmodule

// File: rtl/sra_cell.sv
`timescale 1ns/1ps
module sra_cell
    import sra_pkg::*;
#(
    parameter int EXP_W  = 6,
    parameter int COEF_W = 3,
    parameter int PRIME  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  red_mode_e                 mode,
    input  logic                      flush,
    input  logic                      up_ps_v,
    input  logic [EXP_W+COEF_W-1:0]   up_ps_d,
    input  logic                      up_st_v,
    input  logic [EXP_W+COEF_W-1:0]   up_st_d,
    output logic                      st_v,
    output logic [EXP_W+COEF_W-1:0]   st_d,
    output logic                      ps_v,
    output logic [EXP_W+COEF_W-1:0]   ps_d
);

    localparam int DATA_W = EXP_W + COEF_W;

    typedef struct packed {
        logic              st_v;
        logic [DATA_W-1:0] st_d;
        logic              ps_v;
        logic [DATA_W-1:0] ps_d;
    } cell_state_t;

    cell_state_t cur_q;
    cell_state_t nxt_d;

    logic              exp_match_d;
    logic              full_match_d;
    logic [COEF_W-1:0] coef_sum_d;

    sra_mod_add #(
        .COEF_W (COEF_W),
        .PRIME  (PRIME)
    ) u_coef_add (
        .a   (cur_q.st_d[COEF_W-1:0]),
        .b   (up_ps_d[COEF_W-1:0]),
        .sum (coef_sum_d)
    );

    always_comb begin
        exp_match_d  = (up_ps_d[DATA_W-1:COEF_W] == cur_q.st_d[DATA_W-1:COEF_W]);
        full_match_d = (up_ps_d == cur_q.st_d);
        nxt_d        = cur_q;

        if (flush) begin
            nxt_d.st_v = up_st_v;
            nxt_d.st_d = up_st_d;
            nxt_d.ps_v = 1'b0;
            nxt_d.ps_d = '0;
        end else if (!up_ps_v) begin
            nxt_d.ps_v = 1'b0;
            nxt_d.ps_d = '0;
        end else if (!cur_q.st_v) begin
            nxt_d.st_v = 1'b1;
            nxt_d.st_d = up_ps_d;
            nxt_d.ps_v = 1'b0;
            nxt_d.ps_d = '0;
        end else if (mode == RED_DISTINCT) begin
            if (full_match_d) begin
                nxt_d.ps_v = 1'b0;
                nxt_d.ps_d = '0;
            end else begin
                nxt_d.ps_v = 1'b1;
                nxt_d.ps_d = up_ps_d;
            end
        end else begin
            if (exp_match_d) begin
                nxt_d.st_d[COEF_W-1:0] = coef_sum_d;
                nxt_d.ps_v             = 1'b0;
                nxt_d.ps_d             = '0;
            end else begin
                nxt_d.ps_v = 1'b1;
                nxt_d.ps_d = up_ps_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_v = cur_q.st_v;
    assign st_d = cur_q.st_d;
    assign ps_v = cur_q.ps_v;
    assign ps_d = cur_q.ps_d;

    AST_CAPTURE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && up_ps_v && !cur_q.st_v) |=>
            (cur_q.st_v && cur_q.st_d == $past(up_ps_d) && !cur_q.ps_v)); // R3

    AST_DUP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && mode == RED_DISTINCT && up_ps_v && cur_q.st_v && up_ps_d == cur_q.st_d) |=>
            (!cur_q.ps_v && $stable(cur_q.st_d))); // R2

    AST_MERGE_KEEPS_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && mode == RED_POLYADD && up_ps_v && cur_q.st_v &&
         up_ps_d[DATA_W-1:COEF_W] == cur_q.st_d[DATA_W-1:COEF_W]) |=>
            (!cur_q.ps_v && cur_q.st_v &&
             cur_q.st_d[DATA_W-1:COEF_W] == $past(cur_q.st_d[DATA_W-1:COEF_W]))); // R4

    AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !up_ps_v) |=>
            (!cur_q.ps_v && $stable(cur_q.st_v) && $stable(cur_q.st_d))); // R10

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cur_q.st_v == $past(up_st_v) && !cur_q.ps_v)); // R7

endmodule

// File: rtl/sysred_array.sv
`timescale 1ns/1ps
module sysred_array
    import sra_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int EXP_W  = 6,
    parameter int COEF_W = 3,
    parameter int PRIME  = 7,
    localparam int DATA_W = EXP_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ovf_valid,
    output logic [DATA_W-1:0] ovf_data
);

    localparam int LAST = DEPTH - 1;

    red_mode_e         mode_e;
    logic [DEPTH-1:0]  st_v;
    logic [DEPTH-1:0]  ps_v;
    logic [DEPTH-1:0]  up_st_v;
    logic [DEPTH-1:0]  up_ps_v;
    logic [DATA_W-1:0] st_d    [DEPTH];
    logic [DATA_W-1:0] ps_d    [DEPTH];
    logic [DATA_W-1:0] up_st_d [DEPTH];
    logic [DATA_W-1:0] up_ps_d [DEPTH];

    assign mode_e = red_mode_e'(mode);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == 0) begin : g_head
            assign up_ps_v[g] = in_valid;
            assign up_ps_d[g] = in_data;
            assign up_st_v[g] = 1'b0;
            assign up_st_d[g] = '0;
        end else begin : g_link
            assign up_ps_v[g] = ps_v[g-1];
            assign up_ps_d[g] = ps_d[g-1];
            assign up_st_v[g] = st_v[g-1];
            assign up_st_d[g] = st_d[g-1];
        end

        sra_cell #(
            .EXP_W  (EXP_W),
            .COEF_W (COEF_W),
            .PRIME  (PRIME)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode_e),
            .flush   (flush),
            .up_ps_v (up_ps_v[g]),
            .up_ps_d (up_ps_d[g]),
            .up_st_v (up_st_v[g]),
            .up_st_d (up_st_d[g]),
            .st_v    (st_v[g]),
            .st_d    (st_d[g]),
            .ps_v    (ps_v[g]),
            .ps_d    (ps_d[g])
        );
    end

    logic coef_live_d;

    always_comb begin
        coef_live_d = (mode_e == RED_DISTINCT) || (st_d[LAST][COEF_W-1:0] != '0);
        out_valid   = flush && st_v[LAST] && coef_live_d;
        out_data    = st_d[LAST];
        ovf_valid   = ps_v[LAST];
        ovf_data    = ps_d[LAST];
    end

    AST_NO_OVF_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ovf_valid); // R8

    initial begin
        AST_DEPTH_LEGAL: assert (DEPTH >= 1 && PRIME >= 2 && PRIME < (1 << COEF_W)); // R4
    end

endmodule

// File: tb/sysred_array_test.sv
`timescale 1ns/1ps
module sysred_array_test;

    localparam int DEPTH  = 4;
    localparam int EXP_W  = 6;
    localparam int COEF_W = 3;
    localparam int PRIME  = 7;
    localparam int DW     = EXP_W + COEF_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          flush = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          ovf_valid;
    logic [DW-1:0] ovf_data;

    int            n_checks = 0;
    int            n_fail = 0;
    int            step_no = 0;
    bit            finished = 0;
    logic [DW-1:0] outq [$];
    logic [DW-1:0] ovfq [$];
    int            ovf_at [$];

    sysred_array #(
        .DEPTH  (DEPTH),
        .EXP_W  (EXP_W),
        .COEF_W (COEF_W),
        .PRIME  (PRIME)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ovf_valid (ovf_valid),
        .ovf_data  (ovf_data)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mono(input logic [EXP_W-1:0] e, input logic [COEF_W-1:0] c);
        return {e, c};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [DW-1:0] d, input logic f);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        flush    = f;
        #1;
        if (out_valid) outq.push_back(out_data);
        @(posedge clk);
        #1;
        if (ovf_valid) begin
            ovfq.push_back(ovf_data);
            ovf_at.push_back(step_no);
        end
        step_no++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
    endtask

    task automatic drain(input int n, input logic v, input logic [DW-1:0] d);
        for (int i = 0; i < n; i++) step(v, d, 1'b1);
    endtask

    task automatic restart();
        outq.delete();
        ovfq.delete();
        ovf_at.delete();
        step_no = 0;
    endtask

    task automatic expect_out(input string req, input int idx, input logic [DW-1:0] exp);
        if (idx < outq.size())
            check(outq[idx] == exp, req, $sformatf("out entry %0d", idx), outq[idx], exp);
        else
            check(1'b0, req, $sformatf("out entry %0d missing", idx), 32'hffffffff, exp);
    endtask

    task automatic test_reset();
        restart();
        check(ovf_valid == 1'b0, "R1", "ovf_valid after reset", ovf_valid, 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 0, "R1", "entries emitted from empty chain", outq.size(), 0);
        check(ovfq.size() == 0, "R1", "overflow from empty chain", ovfq.size(), 0);
    endtask

    task automatic test_distinct();
        logic [DW-1:0] a = 9'h000;
        logic [DW-1:0] b = 9'h005;
        logic [DW-1:0] c = 9'h109;
        restart();
        mode = 1'b0;
        step(1'b1, a, 1'b0);
        step(1'b0, 9'h1ff, 1'b0);
        step(1'b1, b, 1'b0);
        step(1'b1, a, 1'b0);
        step(1'b0, 9'h1ff, 1'b0);
        step(1'b1, c, 1'b0);
        step(1'b1, b, 1'b0);
        idle(DEPTH);
        check(ovfq.size() == 0, "R2", "duplicates leaked to overflow", ovfq.size(), 0);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 3, "R2", "distinct result count", outq.size(), 3);
        expect_out("R7", 0, c);
        expect_out("R3", 1, b);
        expect_out("R9", 2, a);
    endtask

    task automatic test_overflow();
        restart();
        mode = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b1, DW'(9'h020 + i), 1'b0);
        idle(DEPTH);
        check(ovfq.size() == 2, "R6", "overflow count", ovfq.size(), 2);
        if (ovfq.size() == 2) begin
            check(ovfq[0] == 9'h024, "R6", "first overflow data", ovfq[0], 9'h024);
            check(ovf_at[0] == 7, "R6", "first overflow cycle", ovf_at[0], 7);
            check(ovfq[1] == 9'h025, "R6", "second overflow data", ovfq[1], 9'h025);
            check(ovf_at[1] == 8, "R6", "second overflow cycle", ovf_at[1], 8);
        end
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == DEPTH, "R7", "full chain drain count", outq.size(), DEPTH);
        expect_out("R7", 0, 9'h023);
        expect_out("R3", 3, 9'h020);
    endtask

    task automatic test_poly_add();
        restart();
        mode = 1'b1;
        step(1'b1, mono(6'h01, 3'd3), 1'b0);
        step(1'b1, mono(6'h12, 3'd2), 1'b0);
        step(1'b1, mono(6'h01, 3'd5), 1'b0);
        step(1'b1, mono(6'h12, 3'd6), 1'b0);
        idle(DEPTH);
        check(ovfq.size() == 0, "R4", "merged terms leaked to overflow", ovfq.size(), 0);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 2, "R4", "summed term count", outq.size(), 2);
        expect_out("R4", 0, mono(6'h12, 3'd1));
        expect_out("R4", 1, mono(6'h01, 3'd1));
    endtask

    task automatic test_cancel();
        restart();
        mode = 1'b1;
        step(1'b1, mono(6'h03, 3'd4), 1'b0);
        step(1'b1, mono(6'h10, 3'd2), 1'b0);
        step(1'b1, mono(6'h03, 3'd3), 1'b0);
        step(1'b1, mono(6'h2a, 3'd1), 1'b0);
        step(1'b1, mono(6'h03, 3'd5), 1'b0);
        idle(DEPTH);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 3, "R5", "terms after cancel and re-add", outq.size(), 3);
        expect_out("R5", 0, mono(6'h2a, 3'd1));
        expect_out("R5", 1, mono(6'h10, 3'd2));
        expect_out("R5", 2, mono(6'h03, 3'd5));
        restart();
        step(1'b1, mono(6'h07, 3'd6), 1'b0);
        step(1'b1, mono(6'h07, 3'd1), 1'b0);
        idle(DEPTH);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 0, "R5", "zero-sum term reported", outq.size(), 0);
        check(ovfq.size() == 0, "R5", "zero-sum overflow", ovfq.size(), 0);
    endtask

    task automatic test_flush_ignores();
        restart();
        mode = 1'b0;
        step(1'b1, 9'h0aa, 1'b0);
        idle(DEPTH);
        drain(DEPTH, 1'b1, 9'h155);
        check(outq.size() == 1, "R8", "entries during flush with input", outq.size(), 1);
        expect_out("R8", 0, 9'h0aa);
        drain(DEPTH, 1'b0, '0);
        check(outq.size() == 1, "R8", "input captured during flush", outq.size(), 1);
        check(ovfq.size() == 0, "R8", "overflow during flush", ovfq.size(), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_distinct();
        test_overflow();
        test_poly_add();
        test_cancel();
        test_flush_ignores();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule